// File: doc/BRIEF.md
# Sticky Interrupt Aggregator with Read-to-Clear Status

The block collects eight event sources into one registered interrupt request line. Four of the sources are general-purpose input pins. Each pin is synchronised, filtered against bounce on a slow tick, and then turned into a one-cycle event on a rising edge, a falling edge or both edges, as software selects. The other four sources are level inputs from a thermal sensor, an auxiliary converter, a touch controller and a supply regulator.

Each source event sets a sticky bit in a 16-bit status word. Reading that word returns its contents and clears it. Events that are still active set their bits again straight away. A mask register blocks chosen sources from the request line, and a global mask forces the line low. Neither mask ever stops the status bits from recording events. The global mask is set at reset, so software has to clear it before any interrupt reaches the rest of the chip.

Software reaches three registers through a simple read/write port. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: Status word layout at address 0: bit 15 thermal, bit 14 GPIO pin 3, bit 13 pin 2, bit 12 pin 1, bit 11 pin 0, bit 10 converter, bit 9 touch, bit 8 regulator. Bits 7:0 read as 0. Every bit is 0 after reset.
- R2: A status bit stays set until address 0 is read. The read returns the pre-clear word on `reg_rdata` one cycle after the strobe, and it clears the bits.
- R3: The mask register at address 1 uses the status bit layout, and a 1 keeps that source off `irq`. Masked sources still set their status bits. Bits 15:8 read back what was written and bits 7:0 read 0. The register resets to 0.
- R4: `irq` is a register that holds the OR of the unmasked status bits with the global mask clear. It follows the status word by one cycle.
- R5: Control bit 8 at address 2 is the global mask. While it is 1, `irq` is 0. It resets to 1.
- R6: A level source still high at the time of a status read sets its bit again, and `irq` stays high.
- R7: An event that arrives in the same cycle as a status read is not in that read's data. It is present in the status word afterwards.
- R8: Each GPIO pin passes through two synchroniser flops. Its filtered level changes only after two consecutive `slow_tick` pulses that both see the new level. With no ticks, no GPIO event occurs. A level seen on only one tick is rejected.
- R9: Control bits 3:0 choose the edge for pins 3..0: 0 selects rising and 1 selects falling. Control bits 7:4 make the matching pin fire on both edges. Both fields reset to 0.
- R10: Writes to address 0 have no effect on the status word.
- R11: The four level inputs set their status bits in every cycle they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| gpio_in | input | 4 | Asynchronous GPIO pin levels |
| therm_evt | input | 1 | Thermal sensor event level |
| adc_evt | input | 1 | Auxiliary converter event level |
| touch_evt | input | 1 | Touch controller event level |
| vreg_evt | input | 1 | Regulator event level |
| slow_tick | input | 1 | One-cycle debounce tick enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume three things about the inputs: `slow_tick` is a single-cycle pulse in the `clk` domain, a read and a write never share a cycle, and the level inputs are synchronous to `clk`. The stimulus drives every strobe, tick and level change on the falling edge and holds it for whole cycles. GPIO pins change only with several idle cycles before the next tick, so the synchroniser has settled before the filter samples. Read strobes never overlap write strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_GPIO  = 4;
  localparam int NUM_LVL   = 4;
  localparam int NUM_SRC   = NUM_GPIO + NUM_LVL;
  localparam int REG_W     = 16;
  localparam int STAT_LSB  = REG_W - NUM_SRC;
  localparam int ADDR_W    = 2;
  localparam int GMASK_BIT = 2 * NUM_GPIO;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_MASK   = 2'd1,
    RA_CTRL   = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/gpio_edge_filter.sv
module gpio_edge_filter #(
  parameter int DEB_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  input  logic fall_sel,
  input  logic both_sel,
  output logic event_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic          s1, s2, filt, filt_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
      cnt    <= '0;
    end else begin
      s1     <= pin;
      s2     <= s1;
      filt_d <= filt;
      if (s2 == filt) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(DEB_TICKS - 1)) begin
          filt <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  logic rose, fell;
  assign rose    = filt & ~filt_d;
  assign fell    = ~filt & filt_d;
  assign event_o = (rose & (both_sel | ~fall_sel)) | (fell & (both_sel | fall_sel));

  // R8: the filtered level moves only on a cycle that carried a tick
  a_r8_filter_on_tick: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> $past(tick));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (clr_i ? '0 : status_q) | set_i;
  end

  assign status_o = status_q;

  // R2: without a clear, no set bit is lost
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R2: a clear with no new events empties the word
  a_r2_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i == '0) |=> (status_q == '0));
  // R7: an event coincident with a clear survives it
  a_r7_no_loss: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int DEB_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic                therm_evt,
  input  logic                adc_evt,
  input  logic                touch_evt,
  input  logic                vreg_evt,
  input  logic                slow_tick,
  output logic                irq
);
  logic [NUM_GPIO-1:0] pol_q, both_q, gpio_ev;
  logic [NUM_SRC-1:0]  mask_q, status, src_set;
  logic                gmask_q, irq_q, clr;
  logic [REG_W-1:0]    rdata_q, ctrl_view;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    gpio_edge_filter #(.DEB_TICKS(DEB_TICKS)) u_filt (
      .clk      (clk),
      .rst      (rst),
      .tick     (slow_tick),
      .pin      (gpio_in[g]),
      .fall_sel (pol_q[g]),
      .both_sel (both_q[g]),
      .event_o  (gpio_ev[g])
    );
  end

  assign src_set = {therm_evt, gpio_ev, adc_evt, touch_evt, vreg_evt};
  assign clr     = reg_rd && (reg_addr == RA_STATUS);

  irq_status_bank #(.N(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (src_set),
    .clr_i    (clr),
    .status_o (status)
  );

  always_comb begin
    ctrl_view                         = '0;
    ctrl_view[NUM_GPIO-1:0]           = pol_q;
    ctrl_view[2*NUM_GPIO-1:NUM_GPIO]  = both_q;
    ctrl_view[GMASK_BIT]              = gmask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      pol_q   <= '0;
      both_q  <= '0;
      gmask_q <= 1'b1;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_MASK: mask_q <= reg_wdata[REG_W-1:STAT_LSB];
          RA_CTRL: begin
            pol_q   <= reg_wdata[NUM_GPIO-1:0];
            both_q  <= reg_wdata[2*NUM_GPIO-1:NUM_GPIO];
            gmask_q <= reg_wdata[GMASK_BIT];
          end
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          RA_STATUS: rdata_q <= {status, {STAT_LSB{1'b0}}};
          RA_MASK:   rdata_q <= {mask_q, {STAT_LSB{1'b0}}};
          RA_CTRL:   rdata_q <= ctrl_view;
          default:   rdata_q <= '0;
        endcase
      end
      irq_q <= ~gmask_q & (|(status & ~mask_q));
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R5: global mask holds the request line low
  a_r5_gmask_blocks: assert property (@(posedge clk) disable iff (rst)
    gmask_q |=> !irq);
  // R3: with every pending bit masked the line stays quiet
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & ~mask_q) == '0) |=> !irq);
  // R4: an unmasked pending bit raises the line one cycle later
  a_r4_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (!gmask_q && (status & ~mask_q) != '0) |=> irq);
  // R10: a status write alone never sets or clears bits
  a_r10_status_write_inert: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rd && reg_addr == RA_STATUS && src_set == '0) |=> $stable(status));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [3:0]  gpio_in = 0;
  logic        therm_evt = 0, adc_evt = 0, touch_evt = 0, vreg_evt = 0;
  logic        slow_tick = 0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
    .therm_evt(therm_evt), .adc_evt(adc_evt), .touch_evt(touch_evt),
    .vreg_evt(vreg_evt), .slow_tick(slow_tick), .irq(irq)
  );

  // fields: levels {therm,adc,touch,vreg}, mask, expected status, expected irq
  localparam logic [36:0] VEC [6] = '{
    {4'b1000, 16'h0000, 16'h8000, 1'b1},
    {4'b0100, 16'h0000, 16'h0400, 1'b1},
    {4'b0010, 16'h0200, 16'h0200, 1'b0},
    {4'b0001, 16'h0000, 16'h0100, 1'b1},
    {4'b1111, 16'h8700, 16'h8700, 1'b0},
    {4'b1010, 16'h8000, 16'h8200, 1'b1}
  };

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic set_lvl(logic [3:0] l);
    {therm_evt, adc_evt, touch_evt, vreg_evt} = l;
  endtask

  task automatic pulse_lvl(logic [3:0] l);
    @(negedge clk); set_lvl(l);
    @(negedge clk); set_lvl(4'b0);
  endtask

  task automatic tick_once();
    @(negedge clk); slow_tick = 1;
    @(negedge clk); slow_tick = 0;
    wait_cyc(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);

    // reset state
    chk("R4 irq after reset", {15'b0, irq}, 16'h0000);
    rd_reg(2, d); chk("R5 R9 control reset", d, 16'h0100);
    rd_reg(1, d); chk("R3 mask reset", d, 16'h0000);
    rd_reg(0, d); chk("R1 status reset", d, 16'h0000);

    // R5: global mask set blocks irq but status records
    pulse_lvl(4'b1000);
    wait_cyc(2);
    chk("R5 irq under global mask", {15'b0, irq}, 16'h0000);
    rd_reg(0, d); chk("R5 status under global mask", d, 16'h8000);

    wr_reg(2, 16'h0000);

    // table walk: R1 R3 R4 R11 R2
    for (int i = 0; i < 6; i++) begin
      wr_reg(1, VEC[i][32:17]);
      pulse_lvl(VEC[i][36:33]);
      wait_cyc(2);
      chk("R4 R3 irq level", {15'b0, irq}, {15'b0, VEC[i][0]});
      rd_reg(0, d); chk("R1 R11 status word", d, VEC[i][16:1]);
      wait_cyc(1);
      chk("R2 irq cleared after read", {15'b0, irq}, 16'h0000);
      rd_reg(0, d); chk("R2 status cleared", d, 16'h0000);
    end
    wr_reg(1, 16'h0000);

    // R3: mask readback
    wr_reg(1, 16'hFFFF);
    rd_reg(1, d); chk("R3 mask readback", d, 16'hFF00);
    wr_reg(1, 16'h0000);

    // R10: status write ignored
    wr_reg(0, 16'hFFFF);
    rd_reg(0, d); chk("R10 status write ignored", d, 16'h0000);
    chk("R10 irq after status write", {15'b0, irq}, 16'h0000);

    // R6: level held across read
    @(negedge clk); therm_evt = 1;
    wait_cyc(2);
    rd_reg(0, d); chk("R6 first read", d, 16'h8000);
    wait_cyc(2);
    chk("R6 irq stays high", {15'b0, irq}, 16'h0001);
    rd_reg(0, d); chk("R6 bit set again", d, 16'h8000);
    @(negedge clk); therm_evt = 0;
    rd_reg(0, d);
    rd_reg(0, d); chk("R6 clears once source drops", d, 16'h0000);

    // R7: event in the read cycle
    @(negedge clk); reg_addr = 0; reg_rd = 1; adc_evt = 1;
    @(negedge clk); reg_rd = 0; adc_evt = 0; d = reg_rdata;
    chk("R7 read shows old value", d, 16'h0000);
    rd_reg(0, d); chk("R7 event kept", d, 16'h0400);

    // R8: rising edge on pin 3 with ticks
    @(negedge clk); gpio_in[3] = 1;
    wait_cyc(4);
    tick_once();
    rd_reg(0, d); chk("R8 one tick not enough", d, 16'h0000);
    tick_once();
    rd_reg(0, d); chk("R8 R9 pin3 rising", d, 16'h4000);

    // R8: no ticks, no event
    @(negedge clk); gpio_in[2] = 1;
    wait_cyc(20);
    rd_reg(0, d); chk("R8 no tick no event", d, 16'h0000);
    tick_once(); tick_once();
    rd_reg(0, d); chk("R8 pin2 after ticks", d, 16'h2000);

    // R9: falling polarity on pin 1
    wr_reg(2, 16'h0002);
    @(negedge clk); gpio_in[1] = 1;
    wait_cyc(4); tick_once(); tick_once();
    rd_reg(0, d); chk("R9 rising ignored when falling selected", d, 16'h0000);
    @(negedge clk); gpio_in[1] = 0;
    wait_cyc(4); tick_once(); tick_once();
    rd_reg(0, d); chk("R9 pin1 falling", d, 16'h1000);

    // R9: both edges on pin 0
    wr_reg(2, 16'h0010);
    @(negedge clk); gpio_in[0] = 1;
    wait_cyc(4); tick_once(); tick_once();
    rd_reg(0, d); chk("R9 both edges rise", d, 16'h0800);
    @(negedge clk); gpio_in[0] = 0;
    wait_cyc(4); tick_once(); tick_once();
    rd_reg(0, d); chk("R9 both edges fall", d, 16'h0800);

    // R8: glitch seen on a single tick is rejected
    @(negedge clk); gpio_in[0] = 1;
    wait_cyc(4); tick_once();
    @(negedge clk); gpio_in[0] = 0;
    wait_cyc(4); tick_once(); tick_once();
    rd_reg(0, d); chk("R8 glitch rejected", d, 16'h0000);

    finish_run();
  end
endmodule